// File: doc/BRIEF.md
# Snoop Coherence Controller with Designated Forwarder

This block holds the coherence state of every tracked line in every cache attached to a shared snoop bus. Its five states are Modified, Exclusive, Shared, Invalid and Forward. Each cache presents a request with an operation code and a line index. The operations are read, write (read-for-ownership) and evict. A round-robin arbiter admits one request per cycle. In that same transaction the controller rewrites the state of the addressed line in all caches. It then reports which agent provides the data and whether memory must absorb a writeback.

A clean shared line has one cache that acts as the designated forwarder. Only that cache answers a read. The role passes to the newest reader, and the old forwarder falls back to Shared. Shared or Forward copies may be dropped at any time with no writeback. If the forwarder has left, a later read is served from memory. A read that memory serves while Shared copies remain is the only way a requester enters Shared.

A combinational peek port returns the states of one line in all caches, so the line table can be observed.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid in every cache, and `grant_o`, `done_o` and `writeback_o` are low. The state code on `peek_state_o` (3 bits per cache, cache c at bits [3c+2:3c]) is I=0, S=1, E=2, F=3, M=4.
- R2: A read that finds no valid copy in any cache is served from memory (`src_mem_o`=1), and the requester enters E.
- R3: A read from an Invalid requester, while another cache holds F, is supplied by the F holder (`src_id_o`). The requester enters F, the former holder drops to S, and caches in S keep S.
- R4: A read from an Invalid requester, while only S copies exist elsewhere, is served from memory, and the requester enters S.
- R5: A read from an Invalid requester, while another cache holds E or M, is supplied by that cache. The supplier drops to S and the requester enters F. `writeback_o` is high exactly when the supplier held M.
- R6: A write leaves the requester in M and every other cache Invalid for that line. The data source is the requester itself if it held a valid copy. Otherwise it is the F, E or M holder, or memory when no such holder exists. `writeback_o` stays low.
- R7: An evict leaves the requester Invalid. `writeback_o` is high only if the requester held M; evicting an S or F copy raises no writeback.
- R8: For any line, at most one cache holds F. While any cache holds M or E, that cache holds the only valid copy.
- R9: Op codes on `req_op_i` (2 bits per cache) are read=0, write=1, evict=2 and no-op=3. Each cycle at most one pending request is granted, in round-robin order starting after the last winner. In the cycle after the grant edge, `grant_o` shows the winner for one cycle and `done_o` pulses with the source fields. A granted bit was requested in the cycle before.
- R10: A read from a cache that already holds a valid copy changes no state. It reports that cache itself as the source, with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CACHES | Request pending, one bit per cache |
| req_op_i | input | 2*N_CACHES | Operation code per cache |
| req_line_i | input | LW*N_CACHES | Line index per cache |
| peek_line_i | input | LW | Line selected for observation |
| grant_o | output | N_CACHES | One-hot grant of the transaction just completed |
| done_o | output | 1 | Transaction completed pulse |
| src_mem_o | output | 1 | Data supplied by main memory |
| src_id_o | output | IW | Supplying cache when src_mem_o is low |
| writeback_o | output | 1 | Modified data must be written to memory |
| peek_state_o | output | 3*N_CACHES | States of peek_line_i in all caches |

## Verification
Arbitration and state update happen in the same cycle. Two caches that read the same line at the same time can therefore see different line states, depending on which one wins. The bench raises reads from two caches to an empty line on the same edge. It takes the first winner from `grant_o`. It then expects that winner to be filled from memory as Exclusive, and the second winner to be supplied by the first and to take Forward. A separate check raises four evicts together and confirms that the grants run consecutively modulo the cache count, with each cache granted once.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } coh_state_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_NOP = 2'd3
  } coh_op_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt_o   = '0;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!valid_o && req_i[j]) begin
        valid_o  = 1'b1;
        idx_o    = IW'(j);
        gnt_o[j] = 1'b1;
      end
    end
  end

  // pointer moves past the winner
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (valid_o) ptr_q <= (int'(idx_o) == N - 1) ? '0 : IW'(int'(idx_o) + 1);
  end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store import coh_pkg::*; #(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [LW-1:0]           wr_line_i,
  input  coh_state_e [N_CACHES-1:0] wr_states_i,
  input  logic [LW-1:0]           rd_line_i,
  output coh_state_e [N_CACHES-1:0] rd_states_o,
  input  logic [LW-1:0]           pk_line_i,
  output coh_state_e [N_CACHES-1:0] pk_states_o,
  output coh_state_e [N_LINES-1:0][N_CACHES-1:0] all_o
);
  coh_state_e [N_LINES-1:0][N_CACHES-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < N_LINES; l++)
        for (int c = 0; c < N_CACHES; c++)
          st_q[l][c] <= ST_I;
    end else if (wr_en_i) begin
      st_q[wr_line_i] <= wr_states_i;
    end
  end

  assign rd_states_o = st_q[rd_line_i];
  assign pk_states_o = st_q[pk_line_i];
  assign all_o       = st_q;
endmodule

// File: rtl/coh_next.sv
module coh_next import coh_pkg::*; #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0]      req_id_i,
  input  coh_op_e            op_i,
  input  coh_state_e [N-1:0] cur_i,
  output coh_state_e [N-1:0] nxt_o,
  output logic               src_mem_o,
  output logic [IW-1:0]      src_id_o,
  output logic               wb_o
);
  logic          has_f, has_own, own_is_m, has_s, req_valid;
  logic [IW-1:0] f_id, own_id;

  // scan the other caches
  always_comb begin
    has_f    = 1'b0;
    has_own  = 1'b0;
    own_is_m = 1'b0;
    has_s    = 1'b0;
    f_id     = '0;
    own_id   = '0;
    for (int i = 0; i < N; i++) begin
      if (i != int'(req_id_i)) begin
        if (cur_i[i] == ST_F) begin
          has_f = 1'b1;
          f_id  = IW'(i);
        end
        if (cur_i[i] == ST_E || cur_i[i] == ST_M) begin
          has_own  = 1'b1;
          own_id   = IW'(i);
          own_is_m = (cur_i[i] == ST_M);
        end
        if (cur_i[i] == ST_S) has_s = 1'b1;
      end
    end
  end

  assign req_valid = (cur_i[req_id_i] != ST_I);

  always_comb begin
    nxt_o     = cur_i;
    src_mem_o = 1'b0;
    src_id_o  = req_id_i;
    wb_o      = 1'b0;
    unique case (op_i)
      OP_RD: begin
        if (req_valid) begin
          // local hit: nothing moves
        end else if (has_f) begin
          nxt_o[f_id]     = ST_S;
          nxt_o[req_id_i] = ST_F;
          src_id_o        = f_id;
        end else if (has_own) begin
          nxt_o[own_id]   = ST_S;
          nxt_o[req_id_i] = ST_F;
          src_id_o        = own_id;
          wb_o            = own_is_m;
        end else if (has_s) begin
          nxt_o[req_id_i] = ST_S;
          src_mem_o       = 1'b1;
        end else begin
          nxt_o[req_id_i] = ST_E;
          src_mem_o       = 1'b1;
        end
      end
      OP_WR: begin
        for (int i = 0; i < N; i++)
          nxt_o[i] = (i == int'(req_id_i)) ? ST_M : ST_I;
        if (req_valid)    src_id_o  = req_id_i;
        else if (has_f)   src_id_o  = f_id;
        else if (has_own) src_id_o  = own_id;
        else              src_mem_o = 1'b1;
      end
      OP_EV: begin
        nxt_o[req_id_i] = ST_I;
        wb_o            = (cur_i[req_id_i] == ST_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl import coh_pkg::*; #(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int IW = (N_CACHES > 1) ? $clog2(N_CACHES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CACHES-1:0]    req_valid_i,
  input  logic [2*N_CACHES-1:0]  req_op_i,
  input  logic [LW*N_CACHES-1:0] req_line_i,
  input  logic [LW-1:0]          peek_line_i,
  output logic [N_CACHES-1:0]    grant_o,
  output logic                   done_o,
  output logic                   src_mem_o,
  output logic [IW-1:0]          src_id_o,
  output logic                   writeback_o,
  output logic [3*N_CACHES-1:0]  peek_state_o
);
  logic [N_CACHES-1:0] arb_gnt;
  logic                arb_valid;
  logic [IW-1:0]       arb_idx;
  coh_op_e             sel_op;
  logic [LW-1:0]       sel_line;
  coh_state_e [N_CACHES-1:0] cur_states, nxt_states, pk_states;
  coh_state_e [N_LINES-1:0][N_CACHES-1:0] all_states;
  logic                nx_src_mem, nx_wb;
  logic [IW-1:0]       nx_src_id;

  coh_rr_arb #(.N(N_CACHES)) arb_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_valid_i),
    .gnt_o   (arb_gnt),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  assign sel_op   = coh_op_e'(req_op_i[2*arb_idx +: 2]);
  assign sel_line = req_line_i[LW*arb_idx +: LW];

  coh_line_store #(.N_CACHES(N_CACHES), .N_LINES(N_LINES)) store_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (arb_valid),
    .wr_line_i   (sel_line),
    .wr_states_i (nxt_states),
    .rd_line_i   (sel_line),
    .rd_states_o (cur_states),
    .pk_line_i   (peek_line_i),
    .pk_states_o (pk_states),
    .all_o       (all_states)
  );

  coh_next #(.N(N_CACHES)) next_i (
    .req_id_i  (arb_idx),
    .op_i      (sel_op),
    .cur_i     (cur_states),
    .nxt_o     (nxt_states),
    .src_mem_o (nx_src_mem),
    .src_id_o  (nx_src_id),
    .wb_o      (nx_wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o     <= '0;
      done_o      <= 1'b0;
      src_mem_o   <= 1'b0;
      src_id_o    <= '0;
      writeback_o <= 1'b0;
    end else begin
      grant_o     <= arb_gnt;
      done_o      <= arb_valid;
      src_mem_o   <= arb_valid & nx_src_mem;
      src_id_o    <= arb_valid ? nx_src_id : '0;
      writeback_o <= arb_valid & nx_wb;
    end
  end

  assign peek_state_o = pk_states;
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk import coh_pkg::*; #(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_CACHES-1:0] req_valid_i,
  input logic [N_CACHES-1:0] grant_o,
  input logic                done_o,
  input logic                src_mem_o,
  input logic                writeback_o,
  input coh_state_e [N_LINES-1:0][N_CACHES-1:0] all_states_i
);
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R9

  AST_DONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (grant_o != '0)); // R9

  AST_WB_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writeback_o |-> (done_o && !src_mem_o)); // R7

  for (genvar c = 0; c < N_CACHES; c++) begin : g_c
    AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[c] |-> $past(req_valid_i[c])); // R9
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_l
    logic [N_CACHES-1:0] fm, om, vm;
    for (genvar c = 0; c < N_CACHES; c++) begin : g_m
      assign fm[c] = (all_states_i[l][c] == ST_F);
      assign om[c] = (all_states_i[l][c] == ST_E) || (all_states_i[l][c] == ST_M);
      assign vm[c] = (all_states_i[l][c] != ST_I);
    end
    AST_FWD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(fm) <= 1); // R8
    AST_OWNER_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (om != '0) |-> ($onehot0(om) && vm == om)); // R8
  end
endmodule

bind coh_snoop_ctrl coh_ctrl_chk #(.N_CACHES(N_CACHES), .N_LINES(N_LINES)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .grant_o      (grant_o),
  .done_o       (done_o),
  .src_mem_o    (src_mem_o),
  .writeback_o  (writeback_o),
  .all_states_i (all_states)
);

// File: tb/coh_snoop_ctrl_tb.sv
module coh_snoop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int LW = 3;
  localparam int IW = 2;
  localparam int SI = 0, SS = 1, SE = 2, SF = 3, SM = 4;
  localparam int RD = 0, WR = 1, EV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [2*NC-1:0]  req_op = '0;
  logic [LW*NC-1:0] req_line = '0;
  logic [LW-1:0]    peek_line = '0;
  logic [NC-1:0]    grant;
  logic             done, src_mem, wb;
  logic [IW-1:0]    src_id;
  logic [3*NC-1:0]  peek_state;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_snoop_ctrl #(.N_CACHES(NC), .N_LINES(NL)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_op_i     (req_op),
    .req_line_i   (req_line),
    .peek_line_i  (peek_line),
    .grant_o      (grant),
    .done_o       (done),
    .src_mem_o    (src_mem),
    .src_id_o     (src_id),
    .writeback_o  (wb),
    .peek_state_o (peek_state)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic st_is(input int line, input int c, input int exp, input string what);
    peek_line = LW'(line);
    #1;
    chk(int'(peek_state[3*c +: 3]), exp, what);
  endtask

  // issue one request; returns outputs seen in the done cycle
  task automatic issue(input int c, input int op, input int line,
                       output int smem, output int sid, output int swb);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_op[2*c +: 2] = 2'(op);
    req_line[LW*c +: LW] = LW'(line);
    do @(negedge clk); while (!grant[c]);
    req_valid[c] = 1'b0;
    smem = int'(src_mem);
    sid  = int'(src_id);
    swb  = int'(wb);
    chk(int'(done), 1, "R9 done with grant");
    @(negedge clk);
    chk(int'(done), 0, "R9 done single pulse");
  endtask

  task automatic t_reset;
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++)
        st_is(l, c, SI, "R1 reset state");
    chk(int'(grant), 0, "R1 grant low");
    chk(int'(done), 0, "R1 done low");
    chk(int'(wb), 0, "R1 writeback low");
  endtask

  task automatic t_read_chain;
    int m, s, w;
    issue(0, RD, 1, m, s, w);
    chk(m, 1, "R2 miss from memory");
    st_is(1, 0, SE, "R2 requester E");
    issue(1, RD, 1, m, s, w);
    chk(m, 0, "R5 E supplies"); chk(s, 0, "R5 supplier id"); chk(w, 0, "R5 E no writeback");
    st_is(1, 0, SS, "R5 supplier S"); st_is(1, 1, SF, "R5 requester F");
    issue(2, RD, 1, m, s, w);
    chk(m, 0, "R3 F supplies"); chk(s, 1, "R3 F holder id");
    st_is(1, 1, SS, "R3 old F to S"); st_is(1, 2, SF, "R3 requester F");
    st_is(1, 0, SS, "R3 sharer unchanged");
  endtask

  task automatic t_silent_evict;
    int m, s, w;
    issue(2, EV, 1, m, s, w);
    chk(w, 0, "R7 F evict silent");
    st_is(1, 2, SI, "R7 evicted I");
    issue(3, RD, 1, m, s, w);
    chk(m, 1, "R4 only S from memory");
    st_is(1, 3, SS, "R4 requester S");
    st_is(1, 0, SS, "R4 other S kept");
  endtask

  task automatic t_local_hit;
    int m, s, w;
    issue(0, RD, 1, m, s, w);
    chk(m, 0, "R10 hit not memory"); chk(s, 0, "R10 own source"); chk(w, 0, "R10 no wb");
    st_is(1, 0, SS, "R10 state kept");
    st_is(1, 3, SS, "R10 others kept");
  endtask

  task automatic t_write_then_read;
    int m, s, w;
    issue(3, WR, 1, m, s, w);
    chk(m, 0, "R6 own copy source"); chk(s, 3, "R6 own id"); chk(w, 0, "R6 no wb");
    for (int c = 0; c < NC; c++) st_is(1, c, (c == 3) ? SM : SI, "R6 M and invalidate");
    issue(0, RD, 1, m, s, w);
    chk(m, 0, "R5 M supplies"); chk(s, 3, "R5 M id"); chk(w, 1, "R5 M writeback");
    st_is(1, 3, SS, "R5 M to S"); st_is(1, 0, SF, "R5 reader F");
    issue(2, WR, 1, m, s, w);
    chk(m, 0, "R6 pull from F"); chk(s, 0, "R6 F holder id");
    for (int c = 0; c < NC; c++) st_is(1, c, (c == 2) ? SM : SI, "R6 pull invalidate");
  endtask

  task automatic t_write_miss_evict;
    int m, s, w;
    issue(1, WR, 2, m, s, w);
    chk(m, 1, "R6 write miss memory");
    st_is(2, 1, SM, "R6 write miss M");
    issue(1, EV, 2, m, s, w);
    chk(w, 1, "R7 M evict writeback");
    st_is(2, 1, SI, "R7 M evict I");
  endtask

  task automatic t_round_robin;
    int prev;
    logic [NC-1:0] seen;
    prev = -1;
    seen = '0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req_op[2*c +: 2] = 2'(EV);
      req_line[LW*c +: LW] = LW'(7);
    end
    req_valid = '1;
    for (int k = 0; k < NC; k++) begin
      int idx;
      @(negedge clk);
      chk($countones(grant), 1, "R9 one grant per cycle");
      idx = 0;
      for (int c = 0; c < NC; c++) if (grant[c]) idx = c;
      if (prev >= 0) chk(idx, (prev + 1) % NC, "R9 round-robin order");
      chk(int'(seen[idx]), 0, "R9 no repeat grant");
      seen[idx] = 1'b1;
      req_valid[idx] = 1'b0;
      prev = idx;
    end
    @(negedge clk);
    chk(int'(done), 0, "R9 idle after drain");
  endtask

  task automatic t_concurrent;
    int w1, w2, m1, s2, m2;
    w1 = -1; w2 = -1; m1 = 0; m2 = 0; s2 = 0;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      req_op[2*c +: 2] = 2'(RD);
      req_line[LW*c +: LW] = LW'(5);
    end
    req_valid = 4'b0011;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) if (grant[c]) begin
        if (k == 0) begin w1 = c; m1 = int'(src_mem); end
        else begin w2 = c; m2 = int'(src_mem); s2 = int'(src_id); end
        req_valid[c] = 1'b0;
      end
    end
    chk(int'(w1 >= 0 && w2 >= 0 && w1 != w2), 1, "R9 both granted");
    chk(m1, 1, "R2 first winner memory");
    chk(m2, 0, "R5 second from cache");
    chk(s2, w1, "R5 second supplied by first");
    if (w1 >= 0) st_is(5, w1, SS, "R5 first drops to S");
    if (w2 >= 0) st_is(5, w2, SF, "R5 second takes F");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_read_chain;
    t_silent_evict;
    t_local_hit;
    t_write_then_read;
    t_write_miss_evict;
    t_round_robin;
    t_concurrent;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule